// File: doc/BRIEF.md
# Indirect PHY Delay Register Access Port

This block gives software access to a small bank of 8-bit PHY delay settings through one 32-bit control word, not through a directly mapped register file. Software first writes the target index and the write byte while both strobes are low. It then raises a write strobe or a read strobe in that same word. The block carries out the access and raises an acknowledge bit. Software polls for that bit and then lowers its strobe. This is a four-phase handshake, and the acknowledge falls once both strobes are low again. After reset or resume, software rewrites each programmed setting this way, one handshake per setting.

The bank holds twelve settings: nine per-speed-mode input delays and three DLL delays (SD clock, high-speed MMC clock, strobe). The delay-line logic reads every setting in parallel from a flat output bus. A small state machine controls each access. It has three states: IDLE waits for a strobe, SETTLE counts out the acknowledge delay, and ACK holds the acknowledge. The transitions are: IDLE to SETTLE on any strobe, with the write committed or the read captured on that edge; SETTLE to ACK after `ACK_DELAY` cycles; ACK to IDLE once both strobes are low.

Top module: `phy_port_bridge`

## Requirements
- R1: Field layout of the control word. Bit 26 is acknowledge (read-only). Bit 25 is the read strobe and bit 24 the write strobe. Bits 23:16 hold the read byte (read-only). Bits 15:8 hold the write byte and bits 5:0 the index. A bus write stores bits 25:24, 15:8 and 5:0, and these read back as written. Bits 31:27 and 7:6 always read zero.
- R2: After reset the control word reads zero and all twelve bank settings are zero.
- R3: Leaving IDLE with the write strobe set stores the write byte into the addressed setting. The delay output places slot k at bits 8k+7:8k. Indices 0x00–0x08 map to slots 0–8, and indices 0x0B, 0x0C and 0x0D map to slots 9, 10 and 11.
- R4: Acknowledge first reads 1 exactly ACK_DELAY+1 clock edges after the edge that stored the strobe. With the default of 2, that is the third edge.
- R5: Acknowledge stays 1 while either strobe is 1. It reads 0 one edge after both strobes have been seen low.
- R6: A read strobe captures the addressed setting into bits 23:16 on the edge that leaves IDLE. This uses the index held before that edge. The field is valid before acknowledge rises and holds while acknowledge is 1.
- R7: Indices outside the twelve mapped ones (for example 0x09, 0x0A, 0x3F) read as zero. Writes to them leave every setting unchanged. Accesses to them are still acknowledged with the R4 latency.
- R8: With both strobes raised together, only the write is performed and bits 23:16 keep their previous value.
- R9: Once an access has been taken, further bus writes made while the strobe stays high do not start a new access. This holds even if they change the write byte or the index.

Ports listed in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Bus write enable for the control word |
| cfg_wdata | input | 32 | Bus write data |
| cfg_rdata | output | 32 | Current control word |
| dly_settings | output | 96 | All bank settings, slot k at bits 8k+7:8k |

## Verification
Two things can happen on the same clock edge: a bus write to the control word, and the read-data capture into that same word. The bench raises the read strobe with index 0x00 on one edge and then, on the very next edge, writes the word again with a different index. That second edge is the one on which the state machine leaves IDLE. The check passes only if the captured byte belongs to the old index, and if the bus write, which never carries the read field, has not overwritten it. The same overlap between bus writes and an active access is also exercised during ACK, where a changed write byte must not reach the bank.

// File: rtl/phy_port_pkg.sv
package phy_port_pkg;
    // Bit positions in the control word; software depends on this layout.
    localparam int ACK_POS   = 26;
    localparam int RDSTB_POS = 25;
    localparam int WRSTB_POS = 24;
    localparam int RDAT_LSB  = 16;
    localparam int WDAT_LSB  = 8;
    localparam int IDX_LSB   = 0;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_ACK    = 2'd2
    } port_state_t;
endpackage

// File: rtl/phy_port_decode.sv
module phy_port_decode #(
    parameter int ADDR_W    = 6,
    parameter int LOW_SPAN  = 9,
    parameter int HIGH_BASE = 11,
    parameter int HIGH_SPAN = 3,
    localparam int SLOTS    = LOW_SPAN + HIGH_SPAN,
    localparam int SLOT_W   = $clog2(SLOTS)
) (
    input  logic [ADDR_W-1:0] index,
    output logic              hit,
    output logic [SLOT_W-1:0] slot
);
    always_comb begin
        hit  = 1'b0;
        slot = '0;
        if (int'(index) < LOW_SPAN) begin
            hit  = 1'b1;
            slot = SLOT_W'(index);
        end else if (int'(index) >= HIGH_BASE && int'(index) < HIGH_BASE + HIGH_SPAN) begin
            hit  = 1'b1;
            slot = SLOT_W'(int'(index) - HIGH_BASE + LOW_SPAN);
        end
    end
endmodule

// File: rtl/phy_port_bank.sv
module phy_port_bank #(
    parameter int DATA_W = 8,
    parameter int SLOTS  = 12,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SLOT_W-1:0]       wr_slot,
    input  logic [DATA_W-1:0]       wr_byte,
    input  logic [SLOT_W-1:0]       rd_slot,
    output logic [DATA_W-1:0]       rd_byte,
    output logic [DATA_W*SLOTS-1:0] flat
);
    logic [DATA_W-1:0] cell_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cell_q[g] <= '0;
            else if (wr_en && int'(wr_slot) == g)
                cell_q[g] <= wr_byte;
        end
        assign flat[g*DATA_W +: DATA_W] = cell_q[g];
    end

    always_comb begin
        rd_byte = '0;
        for (int k = 0; k < SLOTS; k++)
            if (int'(rd_slot) == k)
                rd_byte = cell_q[k];
    end
endmodule

// File: rtl/phy_port_fsm.sv
module phy_port_fsm
    import phy_port_pkg::*;
#(
    parameter int ACK_DELAY = 2,
    localparam int CNT_W    = $clog2(ACK_DELAY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic rd_stb,
    output logic commit_wr,
    output logic capture_rd,
    output logic ack
);
    port_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register and settle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == ST_SETTLE) ? cnt_q + 1'b1 : '0;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (wr_stb || rd_stb) state_d = ST_SETTLE;
            ST_SETTLE: if (cnt_q == CNT_W'(ACK_DELAY - 1)) state_d = ST_ACK;
            ST_ACK:    if (!wr_stb && !rd_stb) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        commit_wr  = 1'b0;
        capture_rd = 1'b0;
        ack        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                commit_wr  = wr_stb;
                capture_rd = rd_stb && !wr_stb;
            end
            ST_SETTLE: ;
            ST_ACK:    ack = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/phy_port_bridge.sv
module phy_port_bridge
    import phy_port_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 6,
    parameter int LOW_SPAN  = 9,
    parameter int HIGH_BASE = 11,
    parameter int HIGH_SPAN = 3,
    parameter int ACK_DELAY = 2,
    localparam int SLOTS    = LOW_SPAN + HIGH_SPAN,
    localparam int SLOT_W   = $clog2(SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [31:0]             cfg_wdata,
    output logic [31:0]             cfg_rdata,
    output logic [DATA_W*SLOTS-1:0] dly_settings
);
    logic [ADDR_W-1:0] idx_q;
    logic [DATA_W-1:0] wbyte_q, rbyte_q, bank_rd;
    logic              wr_q, rd_q;
    logic              hit, commit_wr, capture_rd, ack;
    logic [SLOT_W-1:0] slot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            wbyte_q <= '0;
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
        end else if (cfg_we) begin
            idx_q   <= cfg_wdata[IDX_LSB +: ADDR_W];
            wbyte_q <= cfg_wdata[WDAT_LSB +: DATA_W];
            wr_q    <= cfg_wdata[WRSTB_POS];
            rd_q    <= cfg_wdata[RDSTB_POS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rbyte_q <= '0;
        else if (capture_rd)
            rbyte_q <= hit ? bank_rd : '0;
    end

    phy_port_decode #(
        .ADDR_W(ADDR_W), .LOW_SPAN(LOW_SPAN),
        .HIGH_BASE(HIGH_BASE), .HIGH_SPAN(HIGH_SPAN)
    ) u_dec (
        .index(idx_q), .hit(hit), .slot(slot)
    );

    phy_port_bank #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit_wr && hit), .wr_slot(slot), .wr_byte(wbyte_q),
        .rd_slot(slot), .rd_byte(bank_rd), .flat(dly_settings)
    );

    phy_port_fsm #(.ACK_DELAY(ACK_DELAY)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_q), .rd_stb(rd_q),
        .commit_wr(commit_wr), .capture_rd(capture_rd), .ack(ack)
    );

    always_comb begin
        cfg_rdata = '0;
        cfg_rdata[ACK_POS]                = ack;
        cfg_rdata[RDSTB_POS]              = rd_q;
        cfg_rdata[WRSTB_POS]              = wr_q;
        cfg_rdata[RDAT_LSB +: DATA_W]     = rbyte_q;
        cfg_rdata[WDAT_LSB +: DATA_W]     = wbyte_q;
        cfg_rdata[IDX_LSB +: ADDR_W]      = idx_q;
    end

    logic unused_wbits;
    assign unused_wbits = ^{cfg_wdata[31:26], cfg_wdata[23:16], cfg_wdata[7:6]};
endmodule

// File: rtl/phy_port_chk.sv
module phy_port_chk #(
    parameter int DLY_W     = 96,
    parameter int ACK_DELAY = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      cfg_rdata,
    input logic [DLY_W-1:0] dly_settings
);
    logic ack, rds, wrs;
    assign ack = cfg_rdata[26];
    assign rds = cfg_rdata[25];
    assign wrs = cfg_rdata[24];

    logic [7:0] wait_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wait_cnt <= '0;
        else if ((wrs || rds) && !ack)
            wait_cnt <= (wait_cnt == 8'hFF) ? wait_cnt : wait_cnt + 8'd1;
        else
            wait_cnt <= '0;
    end

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[31:27] == 5'd0 && cfg_rdata[7:6] == 2'd0);

    // R4
    ack_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wait_cnt) <= ACK_DELAY + 1);

    // R5
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (wrs || rds)) |=> ack);

    // R5
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wrs && !rds) |=> !ack);

    // R6
    rbyte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> $stable(cfg_rdata[23:16]));

    // R9
    bank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrs || ack) |=> $stable(dly_settings));
endmodule

bind phy_port_bridge phy_port_chk #(
    .DLY_W(DATA_W * SLOTS), .ACK_DELAY(ACK_DELAY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .dly_settings(dly_settings)
);

// File: tb/sim_phy_port_bridge.sv
module sim_phy_port_bridge;
    localparam int SLOTS = 12;
    localparam logic [31:0] WR = 32'h0100_0000;
    localparam logic [31:0] RD = 32'h0200_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [8*SLOTS-1:0] dly_settings;

    int total = 0;
    int fails = 0;
    logic [7:0] model [SLOTS];

    always #2 clk = ~clk;

    phy_port_bridge u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .dly_settings(dly_settings)
    );

    function automatic int slot_of(input int a);
        if (a <= 8) return a;
        if (a >= 11 && a <= 13) return a - 2;
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge, returns at the negedge after the capturing edge
    task automatic bus_wr(input logic [31:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_ack(output int n);
        n = 0;
        while (!cfg_rdata[26] && n < 40) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic slot_chk(input string req);
        for (int k = 0; k < SLOTS; k++)
            check(dly_settings[k*8 +: 8] == model[k], req, 32'(dly_settings[k*8 +: 8]), 32'(model[k]));
    endtask

    task automatic phy_write(input int a, input logic [7:0] d);
        int n;
        logic [31:0] base;
        base = {16'd0, d, 2'b00, 6'(a)};
        bus_wr(base);
        bus_wr(base | WR);
        wait_ack(n);
        check(n == 3, "R4 write ack latency", 32'(n), 32'd3);
        if (slot_of(a) >= 0) model[slot_of(a)] = d;
        bus_wr(base);
        check(cfg_rdata[26] == 1'b1, "R5 ack held until strobe seen low", 32'(cfg_rdata[26]), 32'd1);
        @(negedge clk);
        check(cfg_rdata[26] == 1'b0, "R5 ack drop", 32'(cfg_rdata[26]), 32'd0);
    endtask

    task automatic phy_read(input int a, output logic [7:0] d);
        int n;
        bus_wr({26'd0, 6'(a)} | RD);
        wait_ack(n);
        check(n == 3, "R4 read ack latency", 32'(n), 32'd3);
        d = cfg_rdata[23:16];
        bus_wr({26'd0, 6'(a)});
        @(negedge clk);
    endtask

    task automatic t_reset;
        check(cfg_rdata == 32'd0, "R2 reset word", cfg_rdata, 32'd0);
        check(dly_settings == '0, "R2 reset bank", 32'(dly_settings[31:0]), 32'd0);
    endtask

    task automatic t_fields;
        bus_wr(32'hFCFF_FFFF);
        check(cfg_rdata == 32'h0000_FF3F, "R1 field readback", cfg_rdata, 32'h0000_FF3F);
        bus_wr(32'h0300_0000);
        check(cfg_rdata[25:24] == 2'b11, "R1 strobe bits", 32'(cfg_rdata[25:24]), 32'd3);
        repeat (6) @(negedge clk);
        bus_wr(32'd0);
        @(negedge clk);
        check(cfg_rdata == 32'd0, "R1 cleared word", cfg_rdata, 32'd0);
    endtask

    task automatic t_write_all;
        for (int a = 0; a < 14; a++)
            if (slot_of(a) >= 0) phy_write(a, 8'(a * 17 + 3));
        slot_chk("R3 slot mapping");
    endtask

    task automatic t_read_all;
        logic [7:0] d;
        for (int a = 0; a < 14; a++)
            if (slot_of(a) >= 0) begin
                phy_read(a, d);
                check(d == model[slot_of(a)], "R6 read byte", 32'(d), 32'(model[slot_of(a)]));
            end
    endtask

    task automatic t_unmapped;
        logic [7:0] d;
        phy_write(9, 8'hAA);
        phy_write(63, 8'h55);
        slot_chk("R7 unmapped write ignored");
        phy_read(12, d);
        phy_read(10, d);
        check(d == 8'd0, "R7 unmapped reads zero", 32'(d), 32'd0);
    endtask

    task automatic t_both;
        logic [7:0] d, prev;
        int n;
        phy_read(2, prev);
        bus_wr({16'd0, 8'h5A, 8'd4} | WR | RD);
        wait_ack(n);
        check(n == 3, "R8 ack latency", 32'(n), 32'd3);
        model[4] = 8'h5A;
        d = cfg_rdata[23:16];
        check(d == prev, "R8 read field unchanged", 32'(d), 32'(prev));
        slot_chk("R8 write performed");
        bus_wr(32'd0);
        @(negedge clk);
    endtask

    task automatic t_hold;
        int n;
        bus_wr({16'd0, 8'h33, 8'd1} | WR);
        wait_ack(n);
        model[1] = 8'h33;
        bus_wr({16'd0, 8'h77, 8'd5} | WR);
        repeat (4) @(negedge clk);
        check(cfg_rdata[26] == 1'b1, "R9 ack stays", 32'(cfg_rdata[26]), 32'd1);
        slot_chk("R9 no second access");
        bus_wr(32'd0);
        @(negedge clk);
        check(cfg_rdata[26] == 1'b0, "R5 ack drop after hold", 32'(cfg_rdata[26]), 32'd0);
    endtask

    task automatic t_collide;
        int n;
        bus_wr(RD | 32'd0);
        bus_wr(RD | 32'd5);
        wait_ack(n);
        check(cfg_rdata[23:16] == model[0], "R6 capture uses prior index", 32'(cfg_rdata[23:16]), 32'(model[0]));
        check(cfg_rdata[5:0] == 6'd5, "R1 index updated", 32'(cfg_rdata[5:0]), 32'd5);
        bus_wr(32'd0);
        @(negedge clk);
    endtask

    initial begin
        #200000;
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int k = 0; k < SLOTS; k++) model[k] = 8'd0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_fields();
        t_write_all();
        t_read_all();
        t_unmapped();
        t_both();
        t_hold();
        t_collide();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule